// File: doc/BRIEF.md
# CMOS Configuration and Clock Register Port

This block puts a 128-byte configuration store behind a byte-wide bus that has two addresses. The host writes an index byte to one address and then reads or writes the selected byte through the other address. Most locations are ordinary storage. A few locations are replaced on read by live packed-BCD time values from a separate calendar block, or by fixed status bytes. Writing zero through one reserved index asks for a system reset and leaves the store untouched.

The bytes that report memory size are loaded at reset from two parameters. One parameter gives the memory below the 32-bit gap and the other gives the memory above 4 GB, both in bytes. Everything else resets to zero. Bus access is synchronous. Read data is registered and appears in the cycle after the read strobe.

Top module: `cmos_regport`

## Requirements
- R1: A write to bus offset 0 stores all 8 bits of the index. A read of offset 0 returns that full value. The index is 0x00 after reset.
- R2: A data write (offset 1) stores the byte at location index[6:0]. A data read of a location with no override returns the stored byte. Index bit 7 plays no part in selecting the location.
- R3: Bus offsets other than 0 and 1 are ignored on write, leaving the index and the store unchanged, and they read as 0x00.
- R4: A data write of 0x00 while the full index is 0x8F does not change location 0x0F. Instead, sys_rst_pulse is high for exactly the one cycle after that write. A nonzero data byte at index 0x8F, or a zero byte at index 0x0F, is stored normally and gives no pulse.
- R5: When the full index is 0x00, 0x02, 0x04, 0x06, 0x07, 0x08 or 0x09, a data read returns, in that order, seconds, minutes, hours, weekday, day of month, month and two-digit year from the calendar inputs.
- R6: A data read at index 0x0A returns 0x20 with bit 7 replaced by cal_uip, so the value is 0x20 or 0xA0.
- R7: A data read at index 0x0D returns 0x80. A data read at index 0x32 returns cal_century.
- R8: With index bit 7 set (for example 0x80 or 0x8D), the overrides of R5 to R7 do not apply, and the read returns the stored byte at index[6:0].
- R9: After reset, locations 0x34/0x35 hold (LOW_MEM_BYTES − 16 MiB)/64 KiB, low byte first. The subtraction saturates at 0 and the result is clamped to 0xFFFF. Locations 0x5B/0x5C/0x5D hold HIGH_MEM_BYTES/64 KiB, low byte first, clamped to 0xFFFFFF. All other locations are 0x00.
- R10: rdata changes only in the cycle after rd_en and otherwise holds its value. When a read and a write happen in the same cycle, the read returns the contents from before the write.
- R11: A data write at an overridden index still stores into the array, and that byte can be read through the same location with index bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | BUS_AW | Bus offset: 0 selects the index, 1 selects the data window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cal_sec | input | 8 | Seconds, BCD |
| cal_min | input | 8 | Minutes, BCD |
| cal_hour | input | 8 | Hours, BCD |
| cal_wday | input | 8 | Weekday, BCD |
| cal_mday | input | 8 | Day of month, BCD |
| cal_mon | input | 8 | Month, BCD |
| cal_year | input | 8 | Two-digit year, BCD |
| cal_century | input | 8 | Century, BCD |
| cal_uip | input | 1 | Update-in-progress flag |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
A corrupted index register shows up on the first read of offset 0, and on every data access after it, which then reaches the wrong location. A stored byte that is lost or misaddressed appears one cycle after the read strobe when that location is read back. Reading it through the bit-7 alias separates storage faults from override faults. A reset pulse that fires wrongly or is too wide is visible on the cycle right after the write. A wrong preload appears on the first read of the memory-size locations after reset.

// File: rtl/cmos_regport.sv
module cmos_regport #(
  parameter int unsigned BUS_AW         = 2,
  parameter int unsigned DEPTH          = 128,
  parameter logic [63:0] LOW_MEM_BYTES  = 64'h0000_0000_2000_0000,
  parameter logic [63:0] HIGH_MEM_BYTES = 64'h0000_0000_8000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BUS_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        cal_sec,
  input  logic [7:0]        cal_min,
  input  logic [7:0]        cal_hour,
  input  logic [7:0]        cal_wday,
  input  logic [7:0]        cal_mday,
  input  logic [7:0]        cal_mon,
  input  logic [7:0]        cal_year,
  input  logic [7:0]        cal_century,
  input  logic              cal_uip,
  output logic              sys_rst_pulse
);

  localparam int unsigned SLOT_W = $clog2(DEPTH);
  localparam logic [63:0] LOW_BASE = 64'h0000_0000_0100_0000;
  localparam logic [63:0] EXT_RAW  = (LOW_MEM_BYTES > LOW_BASE) ? ((LOW_MEM_BYTES - LOW_BASE) >> 16) : 64'd0;
  localparam logic [63:0] HIGH_RAW = HIGH_MEM_BYTES >> 16;
  localparam logic [15:0] EXT_UNITS  = (EXT_RAW > 64'hFFFF) ? 16'hFFFF : EXT_RAW[15:0];
  localparam logic [23:0] HIGH_UNITS = (HIGH_RAW > 64'hFF_FFFF) ? 24'hFF_FFFF : HIGH_RAW[23:0];

  function automatic logic [7:0] preload(int unsigned loc);
    case (loc)
      32'h34:  return EXT_UNITS[7:0];
      32'h35:  return EXT_UNITS[15:8];
      32'h5B:  return HIGH_UNITS[7:0];
      32'h5C:  return HIGH_UNITS[15:8];
      32'h5D:  return HIGH_UNITS[23:16];
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] index_q;
  logic [7:0] store [DEPTH];
  logic [7:0] data_view;
  logic [7:0] rd_next;

  wire              sel_idx   = (addr == BUS_AW'(0));
  wire              sel_dat   = (addr == BUS_AW'(1));
  wire [SLOT_W-1:0] slot      = index_q[SLOT_W-1:0];
  wire              reset_hit = wr_en && sel_dat && (index_q == 8'h8F) && (wdata == 8'h00);

  always_comb begin
    data_view = store[slot];
    case (index_q)
      8'h00:   data_view = cal_sec;
      8'h02:   data_view = cal_min;
      8'h04:   data_view = cal_hour;
      8'h06:   data_view = cal_wday;
      8'h07:   data_view = cal_mday;
      8'h08:   data_view = cal_mon;
      8'h09:   data_view = cal_year;
      8'h0A:   data_view = {cal_uip, 7'h20};
      8'h0D:   data_view = 8'h80;
      8'h32:   data_view = cal_century;
      default: ;
    endcase
    rd_next = sel_idx ? index_q : (sel_dat ? data_view : 8'h00);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q       <= 8'h00;
      rdata         <= 8'h00;
      sys_rst_pulse <= 1'b0;
      for (int i = 0; i < DEPTH; i++) store[i] <= preload(i);
    end else begin
      sys_rst_pulse <= reset_hit;
      if (wr_en && sel_idx) index_q <= wdata;
      if (wr_en && sel_dat && !reset_hit) store[slot] <= wdata;
      if (rd_en) rdata <= rd_next;
    end
  end

  // R1
  idx_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_idx) |=> rdata == $past(index_q));
  // R3
  bad_offset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sel_idx && !sel_dat) |=> rdata == 8'h00);
  // R4
  pulse_keeps_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> $stable(store[15]));
  // R6
  status_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_dat && index_q == 8'h0A) |=> (rdata[6:0] == 7'h20) && (rdata[7] == $past(cal_uip)));
  // R7
  status_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_dat && index_q == 8'h0D) |=> rdata == 8'h80);
  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/test_cmos_regport.sv
module test_cmos_regport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, rdata_big, rdata_small;
  logic       pulse, pulse_big, pulse_small;
  logic [7:0] sec = 8'h00, mn = 8'h00, hr = 8'h00, wd = 8'h00, md = 8'h00, mo = 8'h00, yr = 8'h00, cen = 8'h00;
  logic       uip = 1'b0;
  int         errs = 0, checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  cmos_regport i_cmos_regport (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cal_sec(sec), .cal_min(mn), .cal_hour(hr), .cal_wday(wd), .cal_mday(md),
    .cal_mon(mo), .cal_year(yr), .cal_century(cen), .cal_uip(uip), .sys_rst_pulse(pulse));

  cmos_regport #(.LOW_MEM_BYTES(64'h0000_0002_0000_0000), .HIGH_MEM_BYTES(64'h0000_0100_0000_0000)) i_big (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_big), .cal_sec(sec), .cal_min(mn), .cal_hour(hr), .cal_wday(wd), .cal_mday(md),
    .cal_mon(mo), .cal_year(yr), .cal_century(cen), .cal_uip(uip), .sys_rst_pulse(pulse_big));

  cmos_regport #(.LOW_MEM_BYTES(64'h0000_0000_0080_0000), .HIGH_MEM_BYTES(64'h0)) i_small (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_small), .cal_sec(sec), .cal_min(mn), .cal_hour(hr), .cal_wday(wd), .cal_mday(md),
    .cal_mon(mo), .cal_year(yr), .cal_century(cen), .cal_uip(uip), .sys_rst_pulse(pulse_small));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic read_at(logic [7:0] idx, output logic [7:0] d);
    bus_write(2'd0, idx);
    bus_read(2'd1, d);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    check("R10 rdata after reset", rdata, 8'h00);
    check("R4 pulse after reset", {7'h0, pulse}, 8'h00);
    bus_read(2'd0, d); check("R1 index after reset", d, 8'h00);
    bus_write(2'd0, 8'h34); bus_read(2'd1, d);
    check("R9 ext lo", d, 8'h00); check("R9 ext lo clamp", rdata_big, 8'hFF); check("R9 ext lo sat", rdata_small, 8'h00);
    bus_write(2'd0, 8'h35); bus_read(2'd1, d);
    check("R9 ext hi", d, 8'h1F); check("R9 ext hi clamp", rdata_big, 8'hFF); check("R9 ext hi sat", rdata_small, 8'h00);
    bus_write(2'd0, 8'h5B); bus_read(2'd1, d);
    check("R9 high b0", d, 8'h00); check("R9 high b0 clamp", rdata_big, 8'hFF);
    bus_write(2'd0, 8'h5C); bus_read(2'd1, d);
    check("R9 high b1", d, 8'h80); check("R9 high b1 clamp", rdata_big, 8'hFF);
    bus_write(2'd0, 8'h5D); bus_read(2'd1, d);
    check("R9 high b2", d, 8'h00); check("R9 high b2 clamp", rdata_big, 8'hFF); check("R9 high b2 zero", rdata_small, 8'h00);
    read_at(8'h40, d); check("R9 other zero", d, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] d;
    bus_write(2'd0, 8'hA5); bus_read(2'd0, d); check("R1 index A5", d, 8'hA5);
    bus_write(2'd0, 8'h3C); bus_read(2'd0, d); check("R1 index 3C", d, 8'h3C);
  endtask

  task automatic t_store();
    logic [7:0] d;
    bus_write(2'd0, 8'h10); bus_write(2'd1, 8'h3C);
    bus_read(2'd1, d); check("R2 store 10", d, 8'h3C);
    read_at(8'h90, d); check("R2 bit7 alias", d, 8'h3C);
    bus_write(2'd1, 8'hC3);
    read_at(8'h10, d); check("R2 write via alias", d, 8'hC3);
  endtask

  task automatic t_bad_offset();
    logic [7:0] d;
    bus_write(2'd0, 8'h10);
    bus_write(2'd2, 8'h77); bus_write(2'd3, 8'h55);
    bus_read(2'd2, d); check("R3 read off2", d, 8'h00);
    bus_read(2'd3, d); check("R3 read off3", d, 8'h00);
    bus_read(2'd0, d); check("R3 index kept", d, 8'h10);
    bus_read(2'd1, d); check("R3 store kept", d, 8'hC3);
  endtask

  task automatic t_clock();
    logic [7:0] d;
    sec = 8'h59; mn = 8'h47; hr = 8'h23; wd = 8'h07; md = 8'h31; mo = 8'h12; yr = 8'h99; cen = 8'h20;
    read_at(8'h00, d); check("R5 sec", d, 8'h59);
    read_at(8'h02, d); check("R5 min", d, 8'h47);
    read_at(8'h04, d); check("R5 hour", d, 8'h23);
    read_at(8'h06, d); check("R5 wday", d, 8'h07);
    read_at(8'h07, d); check("R5 mday", d, 8'h31);
    read_at(8'h08, d); check("R5 month", d, 8'h12);
    read_at(8'h09, d); check("R5 year", d, 8'h99);
    sec = 8'h05;
    read_at(8'h00, d); check("R5 sec live", d, 8'h05);
  endtask

  task automatic t_status();
    logic [7:0] d;
    uip = 1'b0; read_at(8'h0A, d); check("R6 uip0", d, 8'h20);
    uip = 1'b1; read_at(8'h0A, d); check("R6 uip1", d, 8'hA0);
    uip = 1'b0;
    read_at(8'h0D, d); check("R7 power", d, 8'h80);
    read_at(8'h32, d); check("R7 century", d, 8'h20);
  endtask

  task automatic t_alias();
    logic [7:0] d;
    read_at(8'h80, d); check("R8 0x80 reads store", d, 8'h00);
    bus_write(2'd0, 8'h00); bus_write(2'd1, 8'h5A);
    read_at(8'h00, d); check("R11 override stays", d, 8'h05);
    read_at(8'h80, d); check("R11 stored under override", d, 8'h5A);
    bus_write(2'd0, 8'h0D); bus_write(2'd1, 8'h6B);
    read_at(8'h8D, d); check("R8 0x8D reads store", d, 8'h6B);
  endtask

  task automatic t_reset_req();
    logic [7:0] d;
    bus_write(2'd0, 8'h0F); bus_write(2'd1, 8'h44);
    check("R4 no pulse on normal write", {7'h0, pulse}, 8'h00);
    bus_write(2'd0, 8'h8F); bus_write(2'd1, 8'h00);
    check("R4 pulse high", {7'h0, pulse}, 8'h01);
    @(negedge clk);
    check("R4 pulse one cycle", {7'h0, pulse}, 8'h00);
    read_at(8'h0F, d); check("R4 store untouched", d, 8'h44);
    bus_write(2'd0, 8'h8F); bus_write(2'd1, 8'h12);
    check("R4 nonzero no pulse", {7'h0, pulse}, 8'h00);
    read_at(8'h0F, d); check("R4 nonzero stored", d, 8'h12);
    bus_write(2'd1, 8'h00);
    check("R4 index 0F zero no pulse", {7'h0, pulse}, 8'h00);
    read_at(8'h8F, d); check("R4 index 0F zero stored", d, 8'h00);
  endtask

  task automatic t_timing();
    logic [7:0] d;
    bus_write(2'd0, 8'h20); bus_write(2'd1, 8'h11);
    @(negedge clk);
    addr = 2'd1; wdata = 8'h22; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R10 read before write", rdata, 8'h11);
    repeat (3) @(negedge clk);
    check("R10 rdata holds", rdata, 8'h11);
    bus_read(2'd1, d); check("R10 write landed", d, 8'h22);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_index();
    t_store();
    t_bad_offset();
    t_clock();
    t_status();
    t_alias();
    t_reset_req();
    t_timing();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule